// File: doc/BRIEF.md
# Stochastic Bit-Stream to Binary Converter

This block turns a stochastic pulse stream, whose information lies in the probability that a given bit is one, back into an ordinary unsigned binary word. It counts the ones that arrive during an observation window of a fixed number of clocks. When the window closes, it places that count on a 12-bit output. The output holds that value until the following window closes. Both internal counters restart by themselves, so the block produces a new sample once per window for as long as it is enabled.

The block is idle until an enable from the system start-up sequencer goes high. While the enable is low the block is kept cleared. A network places one of these converters on each of its primary outputs. Each new sample comes with a one-cycle strobe so that a consumer can tell when the output word has changed.

Top module: `stoch_to_bin`

## Requirements
- R1: While reset is asserted, `sample_o` is 0 and `sample_vld_o` is 0.
- R2: While `run_en_i` is low, both counters are cleared on every clock, `sample_o` reads 0 and `sample_vld_o` stays 0, whatever `stream_i` does.
- R3: A window spans exactly WINDOW_LEN (default 255) consecutive enabled clocks. The first sample is latched on the WINDOW_LEN-th enabled clock after `run_en_i` rises, and a new sample follows every WINDOW_LEN clocks after that.
- R4: Each latched sample equals the number of clocks within its window in which `stream_i` was 1. The bit present in the window's final clock is included.
- R5: A window of all zeros yields 0. A window of all ones yields WINDOW_LEN (255).
- R6: `sample_vld_o` is high for exactly one clock after each latch and is low at every other time.
- R7: Between latches, while enabled, `sample_o` keeps its last latched value.
- R8: Consecutive windows split the stream with no gap and no overlap. For a periodic stream, every bit is counted in exactly one window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en_i | input | 1 | Enable from the start-up sequencer; low keeps the block cleared |
| stream_i | input | 1 | Stochastic input bit stream |
| sample_o | output | 12 | Ones count of the most recently completed window |
| sample_vld_o | output | 1 | One-clock strobe marking a newly latched sample |

## Verification
The embedded assertions check the following on every cycle:
- the window position stays within its range;
- the position wraps to zero right after the end of a window;
- the ones count never exceeds the position;
- the strobe never lasts two clocks;
- the output stays unchanged within a window;
- the output is cleared after a disabled clock.

Only the bench's scenarios can show that a sample's value is exactly right and that the first sample arrives on the correct clock after enable. A behavioural reference model compares both outputs on every clock. The scenarios are all-zero, all-one and period-four streams, and an enable that drops partway through a window.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;
  // Default output word width and window length in clocks
  localparam int unsigned SBC_WORD_W = 12;
  localparam int unsigned SBC_WINDOW = 255;
endpackage

// File: rtl/sbc_reset_sync.sv
`timescale 1ns/1ps
module sbc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sbc_window_timer.sv
`timescale 1ns/1ps
module sbc_window_timer #(
  parameter int unsigned W      = 12,
  parameter int unsigned WINDOW = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] pos,
  output logic         last
);
  localparam logic [W-1:0] LAST_POS = W'(WINDOW - 1);

  logic [W-1:0] pos_q, pos_d;

  always_comb begin
    last  = en && (pos_q == LAST_POS);
    pos_d = pos_q;
    if (!en)       pos_d = '0;
    else if (last) pos_d = '0;
    else           pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

  // R3: position never passes the last slot of a window
  assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);

  // R3: end of window is followed by a fresh window
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (pos_q == '0));
endmodule

// File: rtl/sbc_ones_accum.sv
`timescale 1ns/1ps
module sbc_ones_accum #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_i,
  input  logic         clear,
  output logic [W-1:0] sum_now,
  output logic [W-1:0] ones
);
  logic [W-1:0] ones_q, ones_d;

  always_comb begin
    sum_now = ones_q + {{(W-1){1'b0}}, bit_i};
    ones_d  = ones_q;
    if (!en)        ones_d = '0;
    else if (clear) ones_d = '0;
    else            ones_d = sum_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  assign ones = ones_q;

  // R8: a closed window leaves nothing behind for the next one
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clear) |=> (ones_q == '0));
endmodule

// File: rtl/sbc_capture_reg.sv
`timescale 1ns/1ps
module sbc_capture_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         vld
);
  logic [W-1:0] val_q, val_d;
  logic         vld_q, vld_d;

  always_comb begin
    val_d = val_q;
    vld_d = 1'b0;
    if (!en) begin
      val_d = '0;
    end else if (load) begin
      val_d = din;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      vld_q <= 1'b0;
    end else begin
      val_q <= val_d;
      vld_q <= vld_d;
    end
  end

  assign dout = val_q;
  assign vld  = vld_q;

  // R6: the strobe never lasts two clocks
  assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/stoch_to_bin.sv
`timescale 1ns/1ps
module stoch_to_bin
  import sbc_pkg::*;
#(
  parameter int unsigned WORD_W     = SBC_WORD_W,
  parameter int unsigned WINDOW_LEN = SBC_WINDOW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en_i,
  input  logic              stream_i,
  output logic [WORD_W-1:0] sample_o,
  output logic              sample_vld_o
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] win_pos;
  logic              win_last;
  logic [WORD_W-1:0] ones_now;
  logic [WORD_W-1:0] ones_cnt;

  sbc_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sbc_window_timer #(.W(WORD_W), .WINDOW(WINDOW_LEN)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (run_en_i),
    .pos   (win_pos),
    .last  (win_last)
  );

  sbc_ones_accum #(.W(WORD_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (run_en_i),
    .bit_i   (stream_i),
    .clear   (win_last),
    .sum_now (ones_now),
    .ones    (ones_cnt)
  );

  sbc_capture_reg #(.W(WORD_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (run_en_i),
    .load  (win_last),
    .din   (ones_now),
    .dout  (sample_o),
    .vld   (sample_vld_o)
  );

  // R4: ones seen so far cannot exceed clocks elapsed in the window
  assert_ones_bound_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ones_cnt <= win_pos);

  // R2: a disabled clock leaves the output cleared and silent
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_en_i |=> (sample_o == '0) && !sample_vld_o);

  // R7: output is frozen inside an enabled window
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_en_i && !win_last) |=> $stable(sample_o));
endmodule

// File: tb/sim_stoch_to_bin.sv
`timescale 1ns/1ps
module sim_stoch_to_bin;
  localparam int WIN = 255;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic        bs;
  logic [11:0] dut_out;
  logic        dut_vld;

  int checks   = 0;
  int failures = 0;

  // behavioural reference state
  int m_pos   = 0;
  int m_ones  = 0;
  int m_out   = 0;
  int m_vld   = 0;
  int capq[$];
  int last_vld = 0;

  stoch_to_bin u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en_i     (en),
    .stream_i     (bs),
    .sample_o     (dut_out),
    .sample_vld_o (dut_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model: count enabled clocks and ones, publish at window end
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      m_pos = 0; m_ones = 0; m_out = 0; m_vld = 0;
    end else begin
      int t;
      t = m_ones + (bs ? 1 : 0);
      if (m_pos == WIN - 1) begin
        m_out = t; m_vld = 1; m_pos = 0; m_ones = 0;
      end else begin
        m_vld = 0; m_pos = m_pos + 1; m_ones = t;
      end
    end
  end

  task automatic expect_val(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic e, input logic b);
    string tag;
    en = e;
    bs = b;
    @(negedge clk);
    expect_val("R6 strobe", int'(dut_vld), m_vld);
    if (!e)         tag = "R2 idle output";
    else if (m_vld) tag = "R4 latched value";
    else            tag = "R7 held output";
    expect_val(tag, int'(dut_out), m_out);
    last_vld = m_vld;
    if (m_vld != 0) capq.push_back(m_out);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    en = 1'b0; bs = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_val("R1 reset output", int'(dut_out), 0);
    expect_val("R1 reset strobe", int'(dut_vld), 0);
    rst_n = 1'b1;

    // R2: disabled with ones on the stream
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);

    // R5: all-zero window
    for (int i = 0; i < WIN; i++) step(1'b1, 1'b0);
    expect_val("R3 first latch on clock 255", last_vld, 1);
    expect_val("R5 zeros window", capq[$], 0);

    // R5: all-one window
    for (int i = 0; i < WIN; i++) step(1'b1, 1'b1);
    expect_val("R5 ones window", capq[$], 255);

    // R8: period-four pattern 1000 over four windows: 64,64,64,63
    n = capq.size();
    for (int i = 0; i < 4 * WIN; i++) step(1'b1, (i % 4) == 0);
    expect_val("R8 window count", capq.size() - n, 4);
    expect_val("R8 pattern window 1", capq[n],   64);
    expect_val("R8 pattern window 2", capq[n+1], 64);
    expect_val("R8 pattern window 3", capq[n+2], 64);
    expect_val("R8 pattern window 4", capq[n+3], 63);

    // R2/R3: enable drops mid-window, then a full window restarts
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 3; i++)   step(1'b0, 1'b1);
    expect_val("R2 cleared after disable", int'(dut_out), 0);
    n = 0;
    for (int i = 0; i < WIN; i++) begin
      step(1'b1, 1'b1);
      if (last_vld != 0 && n == 0) n = i + 1;
    end
    expect_val("R3 first latch after re-enable", n, WIN);
    expect_val("R4 value after re-enable", capq[$], 255);

    // R4: one-in-three pattern, partial window then a full count check
    for (int i = 0; i < 2 * WIN; i++) step(1'b1, (i % 3) == 0);
    expect_val("R4 one-in-three window", capq[$], 85);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule